// File: doc/BRIEF.md
# Segment Address Translator with Shadow Descriptors

This block turns a logical address, made of a segment register number and an offset, into a linear address. It keeps four segment registers (code, data, extra, stack), numbered 0 to 3. Each register has a hidden shadow that holds the segment base. Every translation reads the base from the shadow, so a translation never touches memory.

The `prot_mode` input picks the behaviour. In real mode, a segment load stores the 16-bit value shifted left by four as the base, in a single cycle. A translation then adds the low 16 bits of the offset to that base and wraps the result to 20 bits. In protected mode, the loaded value is a selector. The block computes the address of the 8-byte descriptor in either the global or the local table, and reads it as two 32-bit words over a request/valid read port. It assembles the 32-bit base from the descriptor and writes it into the shadow. While this fetch runs, the target register is marked busy and translations to it are stalled.

A three-state controller handles the fetch. `ST_IDLE` moves to `ST_FETCH_LO` when a protected-mode load is accepted. `ST_FETCH_LO` moves to `ST_FETCH_HI` when the lower word arrives. `ST_FETCH_HI` returns to `ST_IDLE` when the upper word arrives, and the shadow is written on that same edge. Each state holds while `mem_rvalid` is low.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `lin_valid` is 0, `busy` is 0, `mem_req` is 0 and `ld_ready` is 1.
- R2: In real mode, an accepted load (`ld_valid && ld_ready`) sets that register's base to `ld_value << 4` at the next edge. It raises no `mem_req` and leaves `ld_ready` at 1.
- R3: In real mode, a translation result equals `((base) + xl_offset[15:0]) mod 2^20`. Bits 31:20 of the result are 0, and `xl_offset[31:16]` is ignored.
- R4: A protected-mode selector uses bits 15:3 as the descriptor index and bit 2 as the table select (0 selects `gdt_base`, 1 selects `ldt_base`). Bits 1:0 are ignored. The first read address is the table base plus the index times 8.
- R5: A descriptor fetch makes exactly two reads: the lower word at the descriptor address, then the upper word at that address plus 4. Each read holds `mem_req` and `mem_addr` steady until a cycle with `mem_rvalid` high.
- R6: The fetched base is {upper[31:24], upper[7:0], lower[31:16]}, where lower and upper are the first and second words read.
- R7: From the edge that accepts a protected load until the edge that consumes the second word, `busy` has exactly the bit of the loading register set and `ld_ready` is 0. A load offered while `ld_ready` is 0 is ignored.
- R8: A translation to a busy register drives `xl_stall` high in the same cycle and produces no result. A translation to a register that is not busy proceeds during a fetch.
- R9: In protected mode, a translation result equals `(base + xl_offset) mod 2^32` and raises no `mem_req`.
- R10: An accepted translation (`xl_valid` and not `xl_stall`) raises `lin_valid` for exactly the next cycle, with the result on `lin_addr`.
- R11: A translation in the same cycle as a load to the same register uses the base as it was before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 selects protected translation, 0 selects real mode |
| ld_valid | input | 1 | Segment load request |
| ld_seg | input | 2 | Segment register to load |
| ld_value | input | 16 | Segment value or selector |
| ld_ready | output | 1 | A load can be accepted this cycle |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 2 | Segment register used by the translation |
| xl_offset | input | 32 | Offset of the logical address |
| xl_stall | output | 1 | Translation held off because its register is busy |
| gdt_base | input | 32 | Base of the global descriptor table |
| ldt_base | input | 32 | Base of the local descriptor table |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid; consumes the current request |
| busy | output | 4 | One bit per register whose descriptor is being fetched |
| lin_valid | output | 1 | One-cycle strobe for a result |
| lin_addr | output | 32 | Linear address |

## Verification
Results come one register stage after the request: a translation accepted at edge N is checked shortly after edge N, as `lin_valid`/`lin_addr`, and one cycle later to confirm the strobe has dropped. A real-mode load updates the shadow at its accepting edge, so the bench checks it with a translation in the very next cycle. `busy` and `ld_ready` are checked right after the accepting edge, and the bench then counts edges until `busy` clears, for memories both with and without wait states. Inputs change on falling edges, and outputs are sampled 1 ns after rising edges. `xl_stall` is combinational and is sampled in the cycle of the request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Fetch controller states.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2
    } fetch_state_t;

    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;

    // Assemble the 32-bit segment base from a 64-bit descriptor.
    function automatic logic [31:0] desc_base(input logic [63:0] d);
        return {d[63:56], d[39:32], d[31:16]};
    endfunction

endpackage

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int SEL_W   = 16,
    parameter int ADDR_W  = 32,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SEG_W-1:0]    start_seg,
    input  logic [SEL_W-1:2]    start_sel,
    input  logic [ADDR_W-1:0]   gdt_base,
    input  logic [ADDR_W-1:0]   ldt_base,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_rvalid,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                idle,
    output logic                fill_we,
    output logic [SEG_W-1:0]    fill_seg,
    output logic [ADDR_W-1:0]   fill_base,
    output logic [NUM_SEG-1:0]  busy
);

    localparam int IDX_SHIFT = $clog2(DESC_BYTES);

    fetch_state_t               state_q, state_d;
    logic [SEG_W-1:0]           seg_q;
    logic [ADDR_W-1:0]          addr_q;
    logic [31:0]                lo_q;
    logic [ADDR_W-1:0]          tbl_base;
    logic [ADDR_W-1:0]          idx_off;

    assign tbl_base = start_sel[2] ? ldt_base : gdt_base;
    assign idx_off  = ADDR_W'({start_sel[SEL_W-1:3], {IDX_SHIFT{1'b0}}});

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)      state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_rvalid) state_d = ST_FETCH_HI;
            ST_FETCH_HI: if (mem_rvalid) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                seg_q  <= start_seg;
                addr_q <= tbl_base + idx_off;
            end else if (state_q == ST_FETCH_LO && mem_rvalid) begin
                lo_q   <= mem_rdata;
                addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            end
        end
    end

    // Outputs.
    always_comb begin
        mem_req   = 1'b0;
        idle      = 1'b0;
        fill_we   = 1'b0;
        busy      = '0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_FETCH_LO: begin
                mem_req     = 1'b1;
                busy[seg_q] = 1'b1;
            end
            ST_FETCH_HI: begin
                mem_req     = 1'b1;
                busy[seg_q] = 1'b1;
                fill_we     = mem_rvalid;
            end
            default: idle = 1'b1;
        endcase
    end

    assign mem_addr  = addr_q;
    assign fill_seg  = seg_q;
    assign fill_base = ADDR_W'(desc_base({mem_rdata, lo_q}));

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r5_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_LO && mem_rvalid) |=>
            (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

    a_r7_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));

    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> ($countones(busy) == 1 && !idle));

    a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (busy == '0 && idle));

endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank #(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 32,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                real_we,
    input  logic [SEG_W-1:0]    real_seg,
    input  logic [ADDR_W-1:0]   real_base,
    input  logic                fill_we,
    input  logic [SEG_W-1:0]    fill_seg,
    input  logic [ADDR_W-1:0]   fill_base,
    input  logic [SEG_W-1:0]    rd_seg,
    output logic [ADDR_W-1:0]   rd_base
);

    logic [ADDR_W-1:0] base_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[g] <= '0;
            else if (real_we && real_seg == SEG_W'(g))
                base_q[g] <= real_base;
            else if (fill_we && fill_seg == SEG_W'(g))
                base_q[g] <= fill_base;
        end
    end

    assign rd_base = base_q[rd_seg];

    a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(real_we && fill_we));

endmodule

// File: rtl/seg_lin_stage.sv
module seg_lin_stage #(
    parameter int ADDR_W   = 32,
    parameter int REAL_W   = 20,
    parameter int REAL_OFF = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic                real_mode,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   offset,
    output logic                lin_valid,
    output logic [ADDR_W-1:0]   lin_addr
);

    logic [ADDR_W-1:0] sum_real, sum_prot, sum;

    assign sum_real = (base + ADDR_W'(offset[REAL_OFF-1:0])) & ADDR_W'((64'd1 << REAL_W) - 1);
    assign sum_prot = base + offset;
    assign sum      = real_mode ? sum_real : sum_prot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_valid <= 1'b0;
            lin_addr  <= '0;
        end else begin
            lin_valid <= fire;
            if (fire) lin_addr <= sum;
        end
    end

    a_r3_real_width: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && real_mode) |=> (lin_addr >> REAL_W) == '0);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
    parameter int NUM_SEG = 4,
    parameter int SEL_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int REAL_W  = 20,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_mode,
    input  logic                ld_valid,
    input  logic [SEG_W-1:0]    ld_seg,
    input  logic [SEL_W-1:0]    ld_value,
    output logic                ld_ready,
    input  logic                xl_valid,
    input  logic [SEG_W-1:0]    xl_seg,
    input  logic [ADDR_W-1:0]   xl_offset,
    output logic                xl_stall,
    input  logic [ADDR_W-1:0]   gdt_base,
    input  logic [ADDR_W-1:0]   ldt_base,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_rvalid,
    output logic [NUM_SEG-1:0]  busy,
    output logic                lin_valid,
    output logic [ADDR_W-1:0]   lin_addr
);

    localparam int SHIFT = REAL_W - SEL_W;

    logic               ld_fire, real_we, fetch_start, xl_fire, idle;
    logic               fill_we;
    logic [SEG_W-1:0]   fill_seg;
    logic [ADDR_W-1:0]  fill_base, real_base, rd_base;

    assign ld_ready    = idle;
    assign ld_fire     = ld_valid && idle;
    assign real_we     = ld_fire && !prot_mode;
    assign fetch_start = ld_fire && prot_mode;
    assign real_base   = ADDR_W'({ld_value, {SHIFT{1'b0}}});
    assign xl_stall    = xl_valid && busy[xl_seg];
    assign xl_fire     = xl_valid && !xl_stall;

    seg_fetch_ctrl #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .start_seg  (ld_seg),
        .start_sel  (ld_value[SEL_W-1:2]),
        .gdt_base   (gdt_base),
        .ldt_base   (ldt_base),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .idle       (idle),
        .fill_we    (fill_we),
        .fill_seg   (fill_seg),
        .fill_base  (fill_base),
        .busy       (busy)
    );

    seg_shadow_bank #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .real_we    (real_we),
        .real_seg   (ld_seg),
        .real_base  (real_base),
        .fill_we    (fill_we),
        .fill_seg   (fill_seg),
        .fill_base  (fill_base),
        .rd_seg     (xl_seg),
        .rd_base    (rd_base)
    );

    seg_lin_stage #(.ADDR_W(ADDR_W), .REAL_W(REAL_W), .REAL_OFF(SEL_W)) u_lin (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (xl_fire),
        .real_mode  (!prot_mode),
        .base       (rd_base),
        .offset     (xl_offset),
        .lin_valid  (lin_valid),
        .lin_addr   (lin_addr)
    );

    a_r2_real_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && !prot_mode) |=> (!mem_req && ld_ready));

    a_r8_stall_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_stall) |=> !lin_valid);

    a_r10_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && !xl_stall) |=> lin_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_valid && !xl_stall) |=> !lin_valid);

endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_seg = '0;
    logic [15:0] ld_value = '0;
    logic        ld_ready;
    logic        xl_valid = 1'b0;
    logic [1:0]  xl_seg = '0;
    logic [31:0] xl_offset = '0;
    logic        xl_stall;
    logic [31:0] gdt_base = 32'h0010_2000;
    logic [31:0] ldt_base = 32'h0A00_7F00;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [3:0]  busy;
    logic        lin_valid;
    logic [31:0] lin_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic        mem_slow = 1'b0;
    logic        tog = 1'b0;
    logic [31:0] addr_last = '0;
    logic [31:0] addr_prev = '0;
    int          req_cnt = 0;
    logic [31:0] exp_base [4];
    logic        timeout = 1'b0;

    always #5 clk = ~clk;

    seg_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_value(ld_value), .ld_ready(ld_ready),
        .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_offset(xl_offset), .xl_stall(xl_stall),
        .gdt_base(gdt_base), .ldt_base(ldt_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .busy(busy), .lin_valid(lin_valid), .lin_addr(lin_addr)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h3C5A_A5C3;
    endfunction

    // Memory model: answers on falling edges, optionally every other cycle.
    always @(negedge clk) begin
        tog <= ~tog;
        if (mem_req) req_cnt <= req_cnt + 1;
        if (mem_req && (!mem_slow || tog)) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mword(mem_addr);
            addr_prev  <= addr_last;
            addr_last  <= mem_addr;
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xlate(input logic [1:0] s, input logic [31:0] off,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        xl_valid = 1'b1; xl_seg = s; xl_offset = off;
        #1 check({req, " no stall"}, {31'd0, xl_stall}, 32'd0);
        @(posedge clk); #1;
        xl_valid = 1'b0;
        check({req, " valid"}, {31'd0, lin_valid}, 32'd1);
        check({req, " addr"}, lin_addr, exp);
    endtask

    task automatic load_real(input logic [1:0] s, input logic [15:0] v);
        int c0;
        @(negedge clk);
        c0 = req_cnt;
        ld_valid = 1'b1; ld_seg = s; ld_value = v;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        exp_base[s] = {12'd0, v, 4'd0};
        check("R2 ready stays", {31'd0, ld_ready}, 32'd1);
        @(negedge clk);
        check("R2 no fetch", 32'(req_cnt - c0), 32'd0);
    endtask

    task automatic load_prot(input logic [1:0] s, input logic [15:0] sel);
        logic [31:0] da, lo, hi;
        int n;
        da = (sel[2] ? ldt_base : gdt_base) + {16'd0, sel[15:3], 3'b000};
        lo = mword(da);
        hi = mword(da + 32'd4);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = s; ld_value = sel;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        check("R7 busy set", {28'd0, busy}, 32'(4'b0001 << s));
        check("R7 not ready", {31'd0, ld_ready}, 32'd0);
        n = 0;
        while (busy != 4'd0 && n < 20) begin
            @(posedge clk); #1;
            n++;
        end
        check("R7 busy cleared", {28'd0, busy}, 32'd0);
        check("R4 descriptor addr", addr_prev, da);
        check("R5 upper addr", addr_last, da + 32'd4);
        exp_base[s] = {hi[31:24], hi[7:0], lo[31:16]};
    endtask

    task automatic run_all();
        int c0;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 lin_valid", {31'd0, lin_valid}, 32'd0);
        check("R1 busy", {28'd0, busy}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 ld_ready", {31'd0, ld_ready}, 32'd1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", {30'd0, lin_valid, busy != 4'd0}, 32'd0);
        for (int s = 0; s < 4; s++) exp_base[s] = '0;

        // Real mode sweep: R2, R3, R10
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] v;
                v = (k == 5) ? 16'hFFFF : 16'(k * 16'h3A5B + s * 16'h1111);
                load_real(2'(s), v);
                for (int j = 0; j < 3; j++) begin
                    logic [15:0] o;
                    o = (j == 2) ? 16'hFFFF : 16'(j * 16'h7A31 + k);
                    xlate(2'(s), {16'hDEAD, o},
                          ({12'd0, v, 4'd0} + {16'd0, o}) & 32'h000F_FFFF, "R3 real");
                end
                @(posedge clk); #1;
                check("R10 strobe drops", {31'd0, lin_valid}, 32'd0);
            end
        end

        // R11: load and translate to the same register in one cycle
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 2'd2; ld_value = 16'h4321;
        xl_valid = 1'b1; xl_seg = 2'd2; xl_offset = 32'h0000_0010;
        @(posedge clk); #1;
        ld_valid = 1'b0; xl_valid = 1'b0;
        check("R11 old base used", lin_addr, (exp_base[2] + 32'h10) & 32'h000F_FFFF);
        exp_base[2] = 32'h0004_3210;
        xlate(2'd2, 32'h10, 32'h0004_3220, "R11 new base next");

        // Protected mode sweep: R4, R5, R6, R9
        @(negedge clk) prot_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 2; t++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [12:0] idx;
                    idx = (k == 3) ? 13'h1FFF : 13'(k * 13'h0555 + s);
                    mem_slow = k[0];
                    load_prot(2'(s), {idx, t[0], 2'(k)});
                    c0 = req_cnt;
                    xlate(2'(s), 32'd0, exp_base[s], "R6 base");
                    xlate(2'(s), 32'hFFFF_FFFF, exp_base[s] + 32'hFFFF_FFFF, "R9 wrap");
                    xlate(2'(s), 32'h1234_5678, exp_base[s] + 32'h1234_5678, "R9 add");
                    @(negedge clk);
                    check("R9 no memory access", 32'(req_cnt - c0), 32'd0);
                end
            end
        end
        mem_slow = 1'b0;

        // R4: privilege bits ignored
        load_prot(2'd1, 16'h0053);
        c0 = 0;
        load_prot(2'd3, 16'h0050);
        check("R4 rpl ignored", exp_base[3], exp_base[1]);
        xlate(2'd3, 32'd4, exp_base[1] + 32'd4, "R4 rpl ignored xlate");

        // R8 stall and R7 ignored load during a fetch
        mem_slow = 1'b1;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 2'd1; ld_value = 16'h0108;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        @(negedge clk);
        xl_valid = 1'b1; xl_seg = 2'd1; xl_offset = 32'd0;
        ld_valid = 1'b1; ld_seg = 2'd0; ld_value = 16'h0200;
        #1;
        check("R8 stall high", {31'd0, xl_stall}, 32'd1);
        check("R7 load refused", {31'd0, ld_ready}, 32'd0);
        @(posedge clk); #1;
        xl_valid = 1'b0; ld_valid = 1'b0;
        check("R8 no result", {31'd0, lin_valid}, 32'd0);
        check("R8 still busy", {28'd0, busy}, 32'h2);
        xlate(2'd0, 32'h40, exp_base[0] + 32'h40, "R8 other reg proceeds");
        while (busy != 4'd0) @(posedge clk);
        #1;
        mem_slow = 1'b0;
        begin
            logic [31:0] lo, hi, da;
            da = gdt_base + 32'h108;
            lo = mword(da); hi = mword(da + 32'd4);
            exp_base[1] = {hi[31:24], hi[7:0], lo[31:16]};
        end
        xlate(2'd1, 32'h8, exp_base[1] + 32'h8, "R8 after fetch");
        xlate(2'd0, 32'h0, exp_base[0], "R7 ignored load left base");
        @(posedge clk); #1;
        check("R7 no late fetch", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule